// File: doc/BRIEF.md
# Programmable Delay Trigger Sequencer

This block schedules conversion starts for one converter channel with four pre-triggers. A rising edge on the trigger input is captured by a synchronizing register. It restarts a 16-bit counter from zero, and the counter runs up to a programmable modulus. Each pre-trigger has three ways to fire. In delay mode it fires when the counter reaches its own delay value. In bypass mode it fires a fixed two cycles after the trigger. In back-to-back mode it fires two cycles after the converter acknowledges the previous conversion. When no conversion is outstanding, every pre-trigger pulse is joined by a channel trigger pulse.

Each started conversion holds a per-pre-trigger lock until its conversion-complete input arrives. While any lock is held, the channel trigger is suppressed. A pre-trigger that fires during that time sets a sticky sequence-error flag. A separate status flag is raised when the counter passes a programmable interrupt delay. Depending on the mode, that flag drives either an interrupt or a DMA request.

Software programs the block through a single-cycle write port:

| Address | Contents |
|---|---|
| 0 | Control: bit0 block enable, bit1 continuous, bit2 interrupt enable, bit3 DMA mode, bit4 error-interrupt enable |
| 1 | Pre-trigger setup: bits[3:0] enables, bits[7:4] delay-select, bits[11:8] back-to-back |
| 2 | Modulus |
| 3 | Interrupt delay |
| 4 | Write-one-to-clear: bit0 status flag, bits[4:1] error flags 0..3 |
| 5+m | Delay of pre-trigger m |

Top module: `prog_delay_trig`

## Requirements
- R1: After reset all outputs are low and all registers read as zero.
- R2: A rising edge of trig_in first sampled at clock edge E starts a count sequence. A pre-trigger m is enabled (address 1 bit m) with delay-select set (address 1 bit 4+m) and back-to-back clear (address 1 bit 8+m). Such a pre-trigger pulses for exactly one cycle following edge E+2+D, where D is written at address 5+m, and it fires at most once per count sequence.
- R3: With delay-select of m cleared and back-to-back clear, pre-trigger m pulses for one cycle following edge E+2, whatever its delay value.
- R4: With back-to-back of m set, the trigger input and the delay value of m are ignored. Pre-trigger m pulses for one cycle following edge A+2, where A is the edge that samples ack[m] high.
- R5: The counter returns to zero after equalling the modulus (address 2). With continuous mode (address 0 bit1) set, delay-mode pulses repeat every modulus+1 cycles. Without continuous mode, the counter stops and no further pulse occurs until the next trigger edge.
- R6: chan_trig pulses in the same cycle as a pre-trigger pulse when no lock is held, and that start takes a lock for each pulsing pre-trigger. While any lock is held, chan_trig stays low.
- R7: A pre-trigger pulse that occurs while any lock is held sets error flag m on seq_err. The flag stays set until cleared. err_irq is high when any error flag is set and the error-interrupt enable (address 0 bit4) is set.
- R8: Sampling coco[m] high releases lock m, so the next pre-trigger pulse again carries chan_trig.
- R9: Clearing the enable of pre-trigger m releases lock m, and a disabled pre-trigger never pulses.
- R10: The status flag is set one cycle after the counter equals the interrupt delay (address 3), that is, at edge E+2+I. irq follows the flag when the interrupt enable is set and DMA mode (address 0 bit3) is clear. dma_req follows the flag when DMA mode is set.
- R11: Writing 1 to bit0 of address 4 clears the status flag, and writing 1 to bit 1+m clears error flag m. A set event in the same cycle as the clear leaves the flag set.
- R12: A new trigger edge while the counter runs restarts the sequence from zero, and the pulses of the earlier sequence that are still pending do not occur.
- R13: Clearing the block enable stops the counter, drops all locks and any pending pulses, and keeps every register value, so a re-enabled run behaves as before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 16 | Register write data |
| trig_in | input | 1 | External trigger; rising edge starts a sequence |
| ack | input | 4 | Converter acknowledgment per pre-trigger |
| coco | input | 4 | Conversion complete per pre-trigger |
| pre_trig | output | 4 | Single-cycle pre-trigger pulses |
| chan_trig | output | 1 | Channel trigger pulse |
| seq_err | output | 4 | Sticky sequence-error flags |
| irq | output | 1 | Status interrupt |
| err_irq | output | 1 | Sequence-error interrupt |
| dma_req | output | 1 | DMA request from the status flag |

## Verification
The scoreboard predicts every pre-trigger and channel-trigger pulse cycle by cycle. Any pulse it did not predict fails. Two pre-triggers with different delays fired from one trigger tell the delay comparison apart from the lock path, because the second pulse must lose its channel trigger and set an error. Bypass, back-to-back and a restarting double trigger each move the pulse to a different cycle, so each timing path is separated from the others. Continuous runs that are stopped by disabling the block, followed by a re-enabled run, separate state that must be lost (counter, locks, pipelines) from state that must be kept (registers).

// File: rtl/pdts_pkg.sv
package pdts_pkg;
  // register addresses
  localparam int A_CTRL   = 0;
  localparam int A_PTCFG  = 1;
  localparam int A_MOD    = 2;
  localparam int A_IDLY   = 3;
  localparam int A_CLR    = 4;
  localparam int DLY_BASE = 5;
  // control register bits
  localparam int CTRL_EN   = 0;
  localparam int CTRL_CONT = 1;
  localparam int CTRL_IE   = 2;
  localparam int CTRL_DMA  = 3;
  localparam int CTRL_EIE  = 4;
endpackage

// File: rtl/pdts_counter.sv
module pdts_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             blk_en,
  input  logic             cont_mode,
  input  logic             trig_in,
  input  logic [CNT_W-1:0] mod_val,
  input  logic [CNT_W-1:0] idly_val,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] cnt,
  output logic             running,
  output logic             trig_ev,
  output logic             seq_start,
  output logic             flag
);
  logic trig_d1, trig_d2;
  logic at_mod;

  always_ff @(posedge clk) begin
    if (rst) begin
      trig_d1 <= 1'b0;
      trig_d2 <= 1'b0;
    end else begin
      trig_d1 <= trig_in;
      trig_d2 <= trig_d1;
    end
  end

  assign trig_ev   = blk_en & trig_d1 & ~trig_d2;
  assign at_mod    = running && (cnt == mod_val);
  assign seq_start = trig_ev | (at_mod & cont_mode);

  always_ff @(posedge clk) begin
    if (rst || !blk_en) begin
      cnt     <= '0;
      running <= 1'b0;
    end else if (trig_ev) begin
      cnt     <= '0;
      running <= 1'b1;
    end else if (at_mod) begin
      cnt     <= '0;
      running <= cont_mode;
    end else if (running) begin
      cnt     <= cnt + 1'b1;
    end
  end

  // set has priority over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (rst)                                flag <= 1'b0;
    else if (running && (cnt == idly_val))  flag <= 1'b1;
    else if (flag_clr)                      flag <= 1'b0;
  end
endmodule

// File: rtl/pdts_pretrig.sv
module pdts_pretrig #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             en,
  input  logic             dsel,
  input  logic             b2b,
  input  logic [CNT_W-1:0] dly,
  input  logic [CNT_W-1:0] cnt,
  input  logic             running,
  input  logic             trig_ev,
  input  logic             seq_start,
  input  logic             ack,
  output logic             fire
);
  logic ack_q, stage, fired;
  logic match;

  assign match = en & dsel & ~b2b & running & (cnt == dly) & ~fired;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      ack_q <= 1'b0;
      stage <= 1'b0;
      fired <= 1'b0;
    end else begin
      ack_q <= ack;
      stage <= en & (b2b ? ack_q : (~dsel & trig_ev));
      if (seq_start)  fired <= 1'b0;
      else if (match) fired <= 1'b1;
    end
  end

  assign fire = en & (stage | match);
endmodule

// File: rtl/pdts_lock.sv
module pdts_lock #(
  parameter int NUM_PT = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic [NUM_PT-1:0] fire,
  input  logic [NUM_PT-1:0] pt_en,
  input  logic [NUM_PT-1:0] coco,
  input  logic [NUM_PT-1:0] err_clr,
  output logic [NUM_PT-1:0] pre_trig,
  output logic              chan_trig,
  output logic [NUM_PT-1:0] seq_err
);
  logic [NUM_PT-1:0] lock;
  logic [NUM_PT-1:0] start;
  logic [NUM_PT-1:0] err_set;
  logic              any_lock;

  assign any_lock = |lock;
  assign start    = (any_lock || clr) ? '0 : fire;
  assign err_set  = (any_lock && !clr) ? fire : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_trig  <= '0;
      chan_trig <= 1'b0;
      seq_err   <= '0;
      lock      <= '0;
    end else begin
      pre_trig  <= clr ? '0 : fire;
      chan_trig <= |start;
      seq_err   <= (seq_err & ~err_clr) | err_set;
      for (int m = 0; m < NUM_PT; m++) begin
        if (clr)                        lock[m] <= 1'b0;
        else if (start[m])              lock[m] <= 1'b1;
        else if (coco[m] || !pt_en[m])  lock[m] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/prog_delay_trig.sv
module prog_delay_trig
  import pdts_pkg::*;
#(
  parameter  int NUM_PT = 4,
  parameter  int CNT_W  = 16,
  localparam int ADDR_W = $clog2(DLY_BASE + NUM_PT)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic              trig_in,
  input  logic [NUM_PT-1:0] ack,
  input  logic [NUM_PT-1:0] coco,
  output logic [NUM_PT-1:0] pre_trig,
  output logic              chan_trig,
  output logic [NUM_PT-1:0] seq_err,
  output logic              irq,
  output logic              err_irq,
  output logic              dma_req
);
  logic              blk_en, cont_mode, irq_en, dma_en, eirq_en;
  logic [NUM_PT-1:0] pt_en, pt_dsel, pt_b2b;
  logic [CNT_W-1:0]  mod_r, idly_r;
  logic [CNT_W-1:0]  dly_r [NUM_PT];

  logic              clr_sel, flag_clr;
  logic [NUM_PT-1:0] err_clr;
  logic [CNT_W-1:0]  cnt;
  logic              running, trig_ev, seq_start, flag;
  logic [NUM_PT-1:0] pt_fire;

  always_ff @(posedge clk) begin
    if (rst) begin
      blk_en    <= 1'b0;
      cont_mode <= 1'b0;
      irq_en    <= 1'b0;
      dma_en    <= 1'b0;
      eirq_en   <= 1'b0;
      pt_en     <= '0;
      pt_dsel   <= '0;
      pt_b2b    <= '0;
      mod_r     <= '0;
      idly_r    <= '0;
      for (int m = 0; m < NUM_PT; m++) dly_r[m] <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        ADDR_W'(A_CTRL): begin
          blk_en    <= wr_data[CTRL_EN];
          cont_mode <= wr_data[CTRL_CONT];
          irq_en    <= wr_data[CTRL_IE];
          dma_en    <= wr_data[CTRL_DMA];
          eirq_en   <= wr_data[CTRL_EIE];
        end
        ADDR_W'(A_PTCFG): begin
          pt_en   <= wr_data[NUM_PT-1:0];
          pt_dsel <= wr_data[2*NUM_PT-1:NUM_PT];
          pt_b2b  <= wr_data[3*NUM_PT-1:2*NUM_PT];
        end
        ADDR_W'(A_MOD):  mod_r  <= wr_data;
        ADDR_W'(A_IDLY): idly_r <= wr_data;
        default: ;
      endcase
      for (int m = 0; m < NUM_PT; m++)
        if (wr_addr == ADDR_W'(DLY_BASE + m)) dly_r[m] <= wr_data;
    end
  end

  assign clr_sel  = wr_en && (wr_addr == ADDR_W'(A_CLR));
  assign flag_clr = clr_sel & wr_data[0];
  assign err_clr  = clr_sel ? wr_data[NUM_PT:1] : '0;

  pdts_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .blk_en(blk_en), .cont_mode(cont_mode),
    .trig_in(trig_in), .mod_val(mod_r), .idly_val(idly_r),
    .flag_clr(flag_clr), .cnt(cnt), .running(running),
    .trig_ev(trig_ev), .seq_start(seq_start), .flag(flag)
  );

  for (genvar g = 0; g < NUM_PT; g++) begin : g_pt
    pdts_pretrig #(.CNT_W(CNT_W)) u_pt (
      .clk(clk), .rst(rst), .clr(~blk_en), .en(pt_en[g]),
      .dsel(pt_dsel[g]), .b2b(pt_b2b[g]), .dly(dly_r[g]),
      .cnt(cnt), .running(running), .trig_ev(trig_ev),
      .seq_start(seq_start), .ack(ack[g]), .fire(pt_fire[g])
    );
  end

  pdts_lock #(.NUM_PT(NUM_PT)) u_lock (
    .clk(clk), .rst(rst), .clr(~blk_en), .fire(pt_fire),
    .pt_en(pt_en), .coco(coco), .err_clr(err_clr),
    .pre_trig(pre_trig), .chan_trig(chan_trig), .seq_err(seq_err)
  );

  assign irq     = flag & irq_en & ~dma_en;
  assign dma_req = flag & dma_en;
  assign err_irq = (|seq_err) & eirq_en;
endmodule

// File: rtl/pdts_checker.sv
module pdts_checker #(
  parameter int NUM_PT = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              blk_en,
  input logic [NUM_PT-1:0] err_clr,
  input logic [NUM_PT-1:0] pre_trig,
  input logic              chan_trig,
  input logic [NUM_PT-1:0] seq_err,
  input logic              irq,
  input logic              err_irq,
  input logic              dma_req
);
  // R13: a disabled block emits nothing on the next cycle
  assert_quiet_when_off_R13: assert property (@(posedge clk) disable iff (rst)
    !blk_en |=> (pre_trig == '0 && !chan_trig));

  // R6: a conversion start takes a lock, so no start follows directly
  assert_no_back_to_back_start_R6: assert property (@(posedge clk) disable iff (rst)
    chan_trig |=> !chan_trig);

  // R6: channel trigger only alongside a pre-trigger pulse
  assert_chan_with_pre_R6: assert property (@(posedge clk) disable iff (rst)
    chan_trig |-> (pre_trig != '0));

  // R7: error flags only fall through a clear write
  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (($past(seq_err) & ~seq_err & ~$past(err_clr)) == '0));

  // R7: error interrupt needs a set error flag
  assert_errirq_source_R7: assert property (@(posedge clk) disable iff (rst)
    err_irq |-> (seq_err != '0));

  // R10: interrupt and DMA request never together
  assert_irq_dma_excl_R10: assert property (@(posedge clk) disable iff (rst)
    !(irq && dma_req));
endmodule

bind prog_delay_trig pdts_checker #(.NUM_PT(NUM_PT)) u_chk (
  .clk(clk), .rst(rst), .blk_en(blk_en), .err_clr(err_clr),
  .pre_trig(pre_trig), .chan_trig(chan_trig), .seq_err(seq_err),
  .irq(irq), .err_irq(err_irq), .dma_req(dma_req)
);

// File: tb/sim_prog_delay_trig.sv
`timescale 1ns/1ps
module sim_prog_delay_trig;
  import pdts_pkg::*;
  localparam int N  = 4;
  localparam int W  = 16;
  localparam int AW = $clog2(DLY_BASE + N);

  logic          clk = 1'b0, rst = 1'b1, wr_en = 1'b0, trig_in = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [W-1:0]  wr_data = '0;
  logic [N-1:0]  ack = '0, coco = '0;
  logic [N-1:0]  pre_trig, seq_err;
  logic          chan_trig, irq, err_irq, dma_req;

  int    cyc = 0, n_chk = 0, n_fail = 0, n_unexp = 0;
  string cur_req = "R1";

  typedef struct {
    int           at;
    logic [N-1:0] pt;
    logic         ct;
    string        req;
  } exp_t;
  exp_t exp_q[$];

  prog_delay_trig #(.NUM_PT(N), .CNT_W(W)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .trig_in(trig_in), .ack(ack), .coco(coco), .pre_trig(pre_trig),
    .chan_trig(chan_trig), .seq_err(seq_err), .irq(irq), .err_irq(err_irq),
    .dma_req(dma_req)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // monitor: pops expected pulses, flags unpredicted ones
  always @(negedge clk) begin
    if (!rst) begin
      if (exp_q.size() > 0 && exp_q[0].at == cyc) begin
        exp_t e;
        e = exp_q.pop_front();
        chk(pre_trig == e.pt && chan_trig == e.ct, e.req, "pulse {pre,chan}",
            int'({pre_trig, chan_trig}), int'({e.pt, e.ct}));
      end else if (pre_trig != '0 || chan_trig) begin
        n_unexp++;
        chk(1'b0, cur_req, "unexpected pulse {pre,chan}",
            int'({pre_trig, chan_trig}), 0);
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    chk(1'b0, "watchdog", "run did not finish", 0, 1);
    finish_up();
  end

  task automatic wait_to(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic wr(input int a, input int d);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = W'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic fire_trig(output int c);
    c = cyc; trig_in = 1'b1;
    @(negedge clk);
    trig_in = 1'b0;
  endtask

  task automatic expect_pulse(input int at, input logic [N-1:0] pt,
                              input logic ct, input string req);
    exp_t e;
    e.at = at; e.pt = pt; e.ct = ct; e.req = req;
    exp_q.push_back(e);
  endtask

  initial begin
    int c, c2, snap;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(pre_trig == 0 && !chan_trig, "R1", "pulses after reset", int'({pre_trig, chan_trig}), 0);
    chk(seq_err == 0, "R1", "seq_err after reset", int'(seq_err), 0);
    chk(!irq && !err_irq && !dma_req, "R1", "irq/err_irq/dma", int'({irq, err_irq, dma_req}), 0);

    // R2/R6/R7/R10: two delay-mode pre-triggers
    wr(A_MOD, 20); wr(A_IDLY, 5); wr(DLY_BASE + 0, 3); wr(DLY_BASE + 1, 7);
    wr(A_PTCFG, 'h033); wr(A_CTRL, 'h05);
    cur_req = "R2";
    fire_trig(c);
    expect_pulse(c + 6, 4'b0001, 1'b1, "R2");
    expect_pulse(c + 10, 4'b0010, 1'b0, "R6");
    wait_to(c + 7);  chk(!irq, "R10", "irq before delay", irq, 0);
    wait_to(c + 8);  chk(irq, "R10", "irq at interrupt delay", irq, 1);
    chk(!dma_req, "R10", "dma_req with DMA off", dma_req, 0);
    wait_to(c + 11); chk(seq_err == 4'b0010, "R7", "seq_err", int'(seq_err), 2);
    chk(!err_irq, "R7", "err_irq without enable", err_irq, 0);
    cur_req = "R5"; snap = n_unexp;
    wait_to(c + 45); chk(n_unexp == snap, "R5", "one-shot stopped", n_unexp - snap, 0);

    // R11 clears
    wr(A_CLR, 1);     chk(!irq, "R11", "irq after clear", irq, 0);
    wr(A_CLR, 'b100); chk(seq_err == 0, "R11", "err1 after clear", int'(seq_err), 0);

    // R8: coco releases locks
    cur_req = "R8";
    coco[0] = 1'b1; @(negedge clk); coco[0] = 1'b0;
    fire_trig(c);
    expect_pulse(c + 6, 4'b0001, 1'b1, "R8");
    expect_pulse(c + 10, 4'b0010, 1'b1, "R8");
    wait_to(c + 8); coco[0] = 1'b1; @(negedge clk); coco[0] = 1'b0;
    wait_to(c + 12); chk(seq_err == 0, "R8", "no error after release", int'(seq_err), 0);
    wait_to(c + 30);

    // R9: disabling pre-trigger 1 releases its lock; it stays silent
    cur_req = "R9";
    wr(A_PTCFG, 'h011);
    fire_trig(c);
    expect_pulse(c + 6, 4'b0001, 1'b1, "R9");
    wait_to(c + 12); chk(seq_err == 0, "R9", "no error", int'(seq_err), 0);
    wait_to(c + 30);

    // R3 bypass
    cur_req = "R3";
    wr(A_CTRL, 0); wr(A_CTRL, 'h05); wr(A_PTCFG, 'h001);
    fire_trig(c);
    expect_pulse(c + 3, 4'b0001, 1'b1, "R3");
    wait_to(c + 30);

    // R4 back-to-back on pre-trigger 2, pre-trigger 3 disabled
    cur_req = "R4";
    wr(A_CTRL, 0); wr(A_CTRL, 'h05); wr(DLY_BASE + 2, 4); wr(A_PTCFG, 'h444);
    fire_trig(c);
    wait_to(c + 30);
    c = cyc; ack = 4'b1100; @(negedge clk); ack = '0;
    expect_pulse(c + 3, 4'b0100, 1'b1, "R4");
    wait_to(c + 10);
    c = cyc; ack = 4'b0100; @(negedge clk); ack = '0;
    expect_pulse(c + 3, 4'b0100, 1'b0, "R6");
    wait_to(c + 5);
    chk(seq_err == 4'b0100, "R7", "err2 while locked", int'(seq_err), 4);
    chk(!err_irq, "R7", "err_irq off", err_irq, 0);
    wr(A_CTRL, 'h15); chk(err_irq, "R7", "err_irq with enable", err_irq, 1);

    // R5 continuous, then R13 disable and re-enable
    cur_req = "R5";
    wr(A_CTRL, 0); wr(A_CLR, 'h1F);
    chk(seq_err == 0, "R11", "all errors cleared", int'(seq_err), 0);
    wr(A_MOD, 9); wr(DLY_BASE + 0, 2); wr(A_PTCFG, 'h011); wr(A_CTRL, 'h03);
    fire_trig(c);
    expect_pulse(c + 5, 4'b0001, 1'b1, "R5");
    expect_pulse(c + 15, 4'b0001, 1'b0, "R5");
    expect_pulse(c + 25, 4'b0001, 1'b0, "R5");
    expect_pulse(c + 35, 4'b0001, 1'b0, "R5");
    wait_to(c + 37); wr(A_CTRL, 0);
    cur_req = "R13"; snap = n_unexp;
    wait_to(c + 60);
    chk(n_unexp == snap && exp_q.size() == 0, "R13", "silent after disable", n_unexp - snap, 0);
    wr(A_CTRL, 'h03);
    fire_trig(c);
    expect_pulse(c + 5, 4'b0001, 1'b1, "R13");
    wait_to(c + 7); wr(A_CTRL, 0);
    wait_to(c + 30);

    // R12 restart
    cur_req = "R12";
    wr(A_MOD, 30); wr(DLY_BASE + 0, 10); wr(A_CTRL, 'h01);
    fire_trig(c);
    wait_to(c + 4);
    fire_trig(c2);
    expect_pulse(c2 + 13, 4'b0001, 1'b1, "R12");
    wait_to(c2 + 45);

    // R10 DMA mode, R11 set wins over clear
    cur_req = "R10";
    wr(A_PTCFG, 0); wr(A_IDLY, 5); wr(A_CTRL, 'h0D); wr(A_CLR, 1);
    chk(!dma_req && !irq, "R11", "flag cleared", int'({dma_req, irq}), 0);
    fire_trig(c);
    wait_to(c + 7); wr(A_CLR, 1);
    chk(dma_req, "R11", "set wins over clear", dma_req, 1);
    chk(!irq, "R10", "irq masked in DMA mode", irq, 0);
    wr(A_CLR, 1); chk(!dma_req, "R11", "dma_req after clear", dma_req, 0);

    repeat (5) @(negedge clk);
    chk(exp_q.size() == 0, "R2", "expected pulses left", exp_q.size(), 0);
    finish_up();
  end
endmodule